// File: doc/BRIEF.md
# Key-Sequenced Watchdog Reset Controller

This block supervises a 64-bit up-counter that runs as a system watchdog. Software controls it through one 32-bit control word. That word carries a 16-bit key field and an enable bit. Two magic keys, written in a fixed order with the enable bit set, arm the watchdog. After that, the same ordered pair of keys acts as a service that restarts the count from zero.

Once armed, the watchdog cannot be turned off. A write carrying any key other than the two magic values raises the reset request at once. If no service arrives before the counter reaches the programmed 64-bit period, the request is also raised. The request is a level that stays high until the block itself is reset.

The watchdog responds only when the shared timer-mode field selects watchdog operation and both counter halves are released from their local resets.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, `rstReq` is 0, `wdActive` is 0 and `count` is 0.
- R2: In a control word, the key field is bits 31:16 and the enable bit is bit 14. Writing key 0xA5C6 with the enable bit set, and then key 0xDA7E with the enable bit set, raises `wdActive` on the edge of the second write. On that same edge `count` becomes 0.
- R3: Before the watchdog is active, an accepted write out of order returns it to the initial state without raising `rstReq`. While waiting for the second key, this means any write other than 0xDA7E with the enable bit set. From the initial state, any write other than 0xA5C6 with the enable bit set is ignored. So a later second key does not arm the watchdog.
- R4: A key write with the enable bit (bit 14) clear never arms the watchdog.
- R5: Control writes are ignored unless all three hold: `timerMode` equals 2'b10, `loRun` is 1 and `hiRun` is 1. With `wdActive` high, the counter also advances only under these conditions.
- R6: While active, a write whose key is neither 0xA5C6 nor 0xDA7E sets `rstReq` on the edge of that write.
- R7: While active, key 0xA5C6 followed immediately by key 0xDA7E is a service. It clears `count` to 0 on the edge of the second write.
- R8: While active and with `rstReq` low, `count` rises by one on every edge. On the edge where `count` equals `period`, `rstReq` is set.
- R9: Once high, `rstReq` and `wdActive` stay high until reset. Clearing the enable bit in a later write does not disarm the watchdog.
- R10: While active, the enable bit is ignored. A lone 0xDA7E write is neither a fault nor a service, so the counter keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWrEn | input | 1 | Control word write strobe |
| ctlWrData | input | 32 | Control word: key in 31:16, enable in 14 |
| timerMode | input | 2 | Shared timer-mode field; 2'b10 selects watchdog |
| loRun | input | 1 | Low counter half released from local reset |
| hiRun | input | 1 | High counter half released from local reset |
| period | input | 64 | Timeout compare value |
| count | output | 64 | Watchdog counter |
| wdActive | output | 1 | Sticky armed/enable latch |
| rstReq | output | 1 | Sticky reset request |

## Verification
Each result of this block appears on the clock edge that samples its cause:
- `wdActive` changes on the edge of the second key write.
- `count` clears on that edge, and on the edge that completes a service.
- A bad key sets `rstReq` on the edge of that write.
- A timeout sets `rstReq` on the edge one cycle after `count` first shows the value of `period`.

The bench drives each write for exactly one edge and samples one time unit after that edge. It counts edges from arming, so it expects `count` equal to the number of edges elapsed. For the timeout, it checks `rstReq` low after `period` edges and high after one more.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_IDLE   = 2'd0,
    WD_PRE    = 2'd1,
    WD_ACT    = 2'd2,
    WD_ACT_K1 = 2'd3
  } wdState_t;

  typedef struct packed {
    logic clr;
    logic run;
    logic keyFault;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_fsm.sv
module wdog_fsm
  import wdog_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 16,
  parameter int KEY_LSB = 16,
  parameter int EN_BIT  = 14,
  parameter logic [KEY_W-1:0] KEY_A = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY_B = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wdMode,
  output wdStrobe_t         stb,
  output logic              wdActive
);
  wdState_t state, nextState;
  logic [KEY_W-1:0] key;
  logic enBit, wrOk;

  assign key   = wrData[KEY_LSB +: KEY_W];
  assign enBit = wrData[EN_BIT];
  assign wrOk  = wrEn && wdMode;

  always_comb begin
    nextState    = state;
    stb.clr      = 1'b0;
    stb.keyFault = 1'b0;
    stb.run      = wdMode && (state == WD_ACT || state == WD_ACT_K1);
    case (state)
      WD_IDLE: if (wrOk && key == KEY_A && enBit) nextState = WD_PRE;
      WD_PRE: if (wrOk) begin
        if (key == KEY_B && enBit) begin
          nextState = WD_ACT;
          stb.clr   = 1'b1;
        end else begin
          nextState = WD_IDLE;
        end
      end
      WD_ACT: if (wrOk) begin
        if (key == KEY_A) nextState = WD_ACT_K1;
        else if (key != KEY_B) stb.keyFault = 1'b1;
      end
      WD_ACT_K1: if (wrOk) begin
        if (key == KEY_B) begin
          nextState = WD_ACT;
          stb.clr   = 1'b1;
        end else if (key != KEY_A) begin
          stb.keyFault = 1'b1;
        end
      end
      default: nextState = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= WD_IDLE;
    else       state <= nextState;
  end

  assign wdActive = (state == WD_ACT) || (state == WD_ACT_K1);
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
  import wdog_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        stb,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             rstReq
);
  logic hitPeriod;
  assign hitPeriod = stb.run && !rstReq && (count == period);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      rstReq <= 1'b0;
    end else begin
      if (stb.keyFault || hitPeriod) rstReq <= 1'b1;
      if (stb.clr)                   count <= '0;
      else if (stb.run && !rstReq)   count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 16,
  parameter int KEY_LSB = 16,
  parameter int EN_BIT  = 14,
  parameter int MODE_W  = 2,
  parameter logic [MODE_W-1:0] WD_MODE = 2'b10,
  parameter logic [KEY_W-1:0]  KEY_A = 16'hA5C6,
  parameter logic [KEY_W-1:0]  KEY_B = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [DATA_W-1:0] ctlWrData,
  input  logic [MODE_W-1:0] timerMode,
  input  logic              loRun,
  input  logic              hiRun,
  input  logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  count,
  output logic              wdActive,
  output logic              rstReq
);
  wdStrobe_t stb;
  logic wdMode;
  assign wdMode = (timerMode == WD_MODE) && loRun && hiRun;

  wdog_fsm #(
    .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB),
    .EN_BIT(EN_BIT), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .wrEn(ctlWrEn), .wrData(ctlWrData),
    .wdMode(wdMode), .stb(stb), .wdActive(wdActive)
  );

  wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rstN(rstN), .stb(stb), .period(period),
    .count(count), .rstReq(rstReq)
  );
endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk #(
  parameter int CNT_W   = 64,
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 16,
  parameter int KEY_LSB = 16,
  parameter int MODE_W  = 2,
  parameter logic [MODE_W-1:0] WD_MODE = 2'b10,
  parameter logic [KEY_W-1:0]  KEY_A = 16'hA5C6,
  parameter logic [KEY_W-1:0]  KEY_B = 16'hDA7E
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlWrEn,
  input logic [DATA_W-1:0] ctlWrData,
  input logic [MODE_W-1:0] timerMode,
  input logic              loRun,
  input logic              hiRun,
  input logic [CNT_W-1:0]  count,
  input logic              wdActive,
  input logic              rstReq
);
  logic modeOn, wrOn, badKey;
  assign modeOn = (timerMode == WD_MODE) && loRun && hiRun;
  assign wrOn   = ctlWrEn && modeOn;
  assign badKey = ctlWrData[KEY_LSB +: KEY_W] != KEY_A &&
                  ctlWrData[KEY_LSB +: KEY_W] != KEY_B;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> (!rstReq && !wdActive));

  // R6
  bad_key_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdActive && wrOn && badKey) |=> rstReq);

  // R9
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> rstReq);

  // R9
  active_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdActive |=> wdActive);

  // R5
  no_arm_without_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wdActive && !wrOn) |=> !wdActive);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdActive && modeOn && !rstReq && !ctlWrEn) |=> count == $past(count) + 1'b1);

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeOn && !ctlWrEn) |=> $stable(count));
endmodule

bind wdog_ctrl wdog_ctrl_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB),
  .MODE_W(MODE_W), .WD_MODE(WD_MODE), .KEY_A(KEY_A), .KEY_B(KEY_B)
) u_chk (
  .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
  .timerMode(timerMode), .loRun(loRun), .hiRun(hiRun),
  .count(count), .wdActive(wdActive), .rstReq(rstReq)
);

// File: tb/wdog_ctrl_bench.sv
`timescale 1ns/1ps
module wdog_ctrl_bench;
  localparam logic [31:0] K_A   = 32'hA5C6_4000;
  localparam logic [31:0] K_B   = 32'hDA7E_4000;
  localparam logic [31:0] K_A_N = 32'hA5C6_0000;
  localparam logic [31:0] K_B_N = 32'hDA7E_0000;
  localparam logic [31:0] K_BAD = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [31:0] ctlWrData = '0;
  logic [1:0]  timerMode = 2'b10;
  logic        loRun = 1'b1;
  logic        hiRun = 1'b1;
  logic [63:0] period = 64'd1000;
  logic [63:0] count;
  logic        wdActive;
  logic        rstReq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wdog_ctrl u_wdog_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .timerMode(timerMode), .loRun(loRun), .hiRun(hiRun), .period(period),
    .count(count), .wdActive(wdActive), .rstReq(rstReq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; ctlWrEn = 1'b0;
    timerMode = 2'b10; loRun = 1'b1; hiRun = 1'b1; period = 64'd1000;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = d;
    @(posedge clk); #1;
    ctlWrEn = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    doReset();
    step(1);
    check("R1 rstReq", rstReq, 0);
    check("R1 wdActive", wdActive, 0);
    check("R1 count", count, 0);
  endtask

  task automatic t_arm();
    doReset();
    wr(K_A);
    check("R2 not yet active", wdActive, 0);
    wr(K_B);
    check("R2 active", wdActive, 1);
    check("R2 count zero", count, 0);
    step(5);
    check("R8 counts", count, 5);
  endtask

  task automatic t_order();
    doReset();
    wr(K_A); wr(32'h1234_4000); wr(K_B);
    check("R3 stray key", wdActive, 0);
    check("R3 no reset", rstReq, 0);
    doReset();
    wr(K_B); wr(K_A);
    check("R3 reversed pending", wdActive, 0);
    wr(K_A); wr(K_B);
    check("R3 repeated first key", wdActive, 0);
    check("R3 no reset after", rstReq, 0);
  endtask

  task automatic t_noEn();
    doReset();
    wr(K_A_N); wr(K_B);
    check("R4 first no enable", wdActive, 0);
    wr(K_A); wr(K_B_N);
    check("R4 second no enable", wdActive, 0);
  endtask

  task automatic t_mode();
    doReset();
    timerMode = 2'b01;
    wr(K_A); wr(K_B);
    check("R5 wrong mode", wdActive, 0);
    timerMode = 2'b10; hiRun = 1'b0;
    wr(K_A); wr(K_B);
    check("R5 half in reset", wdActive, 0);
    hiRun = 1'b1;
    wr(K_A); wr(K_B);
    step(3);
    @(negedge clk); loRun = 1'b0;
    step(4);
    check("R5 count frozen", count, 3);
    wr(K_BAD);
    check("R5 bad key ignored", rstReq, 0);
  endtask

  task automatic t_fault();
    doReset();
    wr(K_A); wr(K_B);
    wr(K_BAD);
    check("R6 bad key reset", rstReq, 1);
    step(3);
    check("R9 request sticky", rstReq, 1);
    check("R9 active sticky", wdActive, 1);
  endtask

  task automatic t_service();
    doReset();
    wr(K_A); wr(K_B);
    step(10);
    check("R8 count ten", count, 10);
    wr(K_A);
    check("R7 mid service", count, 11);
    wr(K_B);
    check("R7 cleared", count, 0);
    step(1);
    check("R7 restarts", count, 1);
    check("R7 no reset", rstReq, 0);
  endtask

  task automatic t_bOnly();
    doReset();
    wr(K_A); wr(K_B);
    step(3);
    wr(K_B);
    check("R10 lone second key", count, 4);
    check("R10 no fault", rstReq, 0);
    wr(K_A_N); wr(K_B_N);
    check("R10 enable ignored service", count, 0);
    check("R9 enable clear keeps active", wdActive, 1);
  endtask

  task automatic t_timeout();
    doReset();
    period = 64'd20;
    wr(K_A); wr(K_B);
    step(20);
    check("R8 at period", count, 20);
    check("R8 not yet fired", rstReq, 0);
    step(1);
    check("R8 timeout fired", rstReq, 1);
  endtask

  initial begin
    t_reset();
    t_arm();
    t_order();
    t_noEn();
    t_mode();
    t_fault();
    t_service();
    t_bOnly();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule